// File: doc/BRIEF.md
# Cascaded Biquad Lowpass Filter

This block is the digital shaping filter at the head of a transmit path. It takes signed 10-bit samples, one for each pulse of `in_valid`, and passes each sample through a chain of second-order recursive sections. Each section computes y[n] = B0·x[n] + B1·x[n-1] + B2·x[n-2] − A1·y[n-1] − A2·y[n-2], using direct form I. The filtered 10-bit sample then appears on `out_valid`/`out_sample` for the DAC serializer. The default build has two sections. After reset they hold coefficients for a fourth-order elliptic lowpass response, and both sections are active.

Coefficients are 16-bit two's-complement numbers with 13 fraction bits, so the real value is code/8192. One multiplier serves every product. A controller steps through five multiply-accumulate slots per section, and every sample takes the same number of clocks, whether or not a section is bypassed. A small write port loads a staging copy of each coefficient and each enable bit. The staged set is copied into the working set only when a new sample is accepted, so a write never changes a sample that is already being computed.

The controller has three states:
- `ST_IDLE` waits for a sample.
- `ST_FWD` runs the feed-forward slots (B0, B1, B2), which add to the accumulator.
- `ST_FBK` runs the feedback slots (A1, A2), which subtract from the accumulator.

The transitions are:
- **accept**: `ST_IDLE`→`ST_FWD` when `in_valid` is high.
- **to_feedback**: `ST_FWD`→`ST_FBK` after the B2 slot.
- **next_section**: `ST_FBK`→`ST_FWD` after the A2 slot of any section except the last.
- **finish**: `ST_FBK`→`ST_IDLE` after the A2 slot of the last section.

Top module: `biq_cascade`

## Requirements
- R1: Each enabled section outputs round((B0·x[n] + B1·x[n-1] + B2·x[n-2] − A1·y[n-1] − A2·y[n-2]) / 8192), where the coefficients are signed 16-bit codes. Rounding is done by adding 4096 to the exact sum and then shifting right arithmetically by 13. Section 0 feeds section 1.
- R2: Each section result is saturated to the signed 16-bit state range [−32768, 32767] before it is stored in history or passed on. It never wraps around.
- R3: The final output is saturated to the signed 10-bit range [−512, 511].
- R4: A sample is accepted on a rising edge where `in_valid` is high and the block is idle. `out_valid` then pulses for exactly one cycle, starting 10 rising edges after the accepting edge. The block is idle again one edge later, so samples can be accepted every 11 clocks.
- R5: Bit 0 of a section's enable slot turns that section on. A disabled section passes its input through unchanged and keeps its history frozen. The latency is the same whether sections are enabled or not.
- R6: Reset clears all history and the output. Reset loads section 0 with B0=0x0825, B1=0xF43A, B2=0x0825, A1=0xCEFF, A2=0x1613, and section 1 with B0=0x1DAA, B1=0xCBEF, B2=0x1DAA, A1=0xC7F6, A2=0x1F4D. Both sections are enabled after reset.
- R7: A write with `cfg_wr` high stores `cfg_wdata` in slot `cfg_addr` = 6·section + k. The values of k are 0=B0, 1=B1, 2=B2, 3=A1, 4=A2, and 5=enable, which uses bit 0. A written value first affects the next sample accepted after the write. A sample already in flight uses the values it was accepted with.
- R8: A pulse on `in_valid` while a sample is in flight is ignored. It does not change the output or the filter history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 10 | Signed input sample |
| cfg_wr | input | 1 | Coefficient/enable write strobe |
| cfg_addr | input | 4 | Slot number, 6·section + k |
| cfg_wdata | input | 16 | Coefficient code, or enable in bit 0 |
| out_valid | output | 1 | One-cycle output strobe |
| out_sample | output | 10 | Signed filtered sample |

## Verification
- **Impulse after reset.** An impulse followed by zeros exercises the reset coefficient set in both sections, so a wrong default, tap order or sign is visible in the tail. An alternating square wave of mixed amplitudes tests the rounding direction for negative sums.
- **Integrator with a tiny second section.** A constant drive into a pure integrator in section 0, read out through a very small B0 in section 1, separates saturation of the 16-bit state from wraparound. Full-scale input through gain-4 sections separates output clamping from truncation.
- **Bypass and timing.** Switching sections off and back on shows that bypass passes data through unchanged and that the frozen history resumes correctly. Strobes and coefficient writes placed in the middle of a computation show that only the next sample boundary takes them in.

// File: rtl/biq_pkg.sv
package biq_pkg;

    localparam int NTAPS = 5;   // B0, B1, B2, A1, A2
    localparam int SLOTS = 6;   // per-section address slots (five coefficients + enable)

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_FBK
    } biq_state_e;

    // Reset coefficient codes; sections past the second default to identity (1.0).
    function automatic logic [15:0] coef_default(input int sec, input int tap);
        logic [15:0] v;
        v = (tap == 0) ? 16'h2000 : 16'h0000;
        if (sec == 0) begin
            case (tap)
                0: v = 16'h0825;
                1: v = 16'hF43A;
                2: v = 16'h0825;
                3: v = 16'hCEFF;
                default: v = 16'h1613;
            endcase
        end else if (sec == 1) begin
            case (tap)
                0: v = 16'h1DAA;
                1: v = 16'hCBEF;
                2: v = 16'h1DAA;
                3: v = 16'hC7F6;
                default: v = 16'h1F4D;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/biq_mac.sv
module biq_mac #(
    parameter int CW    = 16,
    parameter int DW    = 16,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    clear,
    input  logic                    sub,
    input  logic signed [CW-1:0]    coef,
    input  logic signed [DW-1:0]    oper,
    output logic signed [ACC_W-1:0] sum
);
    localparam int PW = CW + DW;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_x;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] acc_q;

    assign prod   = coef * oper;
    assign prod_x = ACC_W'(prod);
    assign base   = clear ? '0 : acc_q;
    assign sum    = sub ? (base - prod_x) : (base + prod_x);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum;
        end
    end

endmodule

// File: rtl/biq_hist.sv
module biq_hist #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] x_new,
    input  logic signed [DW-1:0] y_new,
    output logic signed [DW-1:0] x1,
    output logic signed [DW-1:0] x2,
    output logic signed [DW-1:0] y1,
    output logic signed [DW-1:0] y2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1 <= '0;
            x2 <= '0;
            y1 <= '0;
            y2 <= '0;
        end else if (upd) begin
            x2 <= x1;
            x1 <= x_new;
            y2 <= y1;
            y1 <= y_new;
        end
    end

endmodule

// File: rtl/biq_cascade.sv
module biq_cascade
    import biq_pkg::*;
#(
    parameter int IN_W     = 10,
    parameter int STATE_W  = 16,
    parameter int CW       = 16,
    parameter int FRAC     = 13,
    parameter int ACC_W    = 40,
    parameter int SECTIONS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic [IN_W-1:0]                      in_sample,
    input  logic                                 cfg_wr,
    input  logic [$clog2(SECTIONS*SLOTS)-1:0]    cfg_addr,
    input  logic [CW-1:0]                        cfg_wdata,
    output logic                                 out_valid,
    output logic [IN_W-1:0]                      out_sample
);
    localparam int ADDR_W = $clog2(SECTIONS * SLOTS);
    localparam int SEC_W  = (SECTIONS > 1) ? $clog2(SECTIONS) : 1;
    localparam int TAP_W  = $clog2(NTAPS);
    localparam int LAT    = SECTIONS * NTAPS;
    localparam int LC_W   = $clog2(LAT + 1);
    localparam logic [TAP_W-1:0] TAP_LAST    = TAP_W'(NTAPS - 1);
    localparam logic [TAP_W-1:0] TAP_FWD_END = TAP_W'(2);
    localparam logic [SEC_W-1:0] SEC_LAST    = SEC_W'(SECTIONS - 1);

    // ---------------- controller ----------------
    biq_state_e       st_q, st_d;
    logic [TAP_W-1:0] tap_q;
    logic [SEC_W-1:0] sec_q;
    logic             accept, last_tap, last_sec;

    assign accept   = (st_q == ST_IDLE) && in_valid;
    assign last_sec = (sec_q == SEC_LAST);
    assign last_tap = (st_q == ST_FBK) && (tap_q == TAP_LAST);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid) st_d = ST_FWD;
            ST_FWD:  if (tap_q == TAP_FWD_END) st_d = ST_FBK;
            ST_FBK:  if (tap_q == TAP_LAST) st_d = last_sec ? ST_IDLE : ST_FWD;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tap_q <= '0;
            sec_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                tap_q <= '0;
                sec_q <= '0;
            end else if (st_q != ST_IDLE) begin
                if (tap_q == TAP_LAST) begin
                    tap_q <= '0;
                    sec_q <= last_sec ? '0 : SEC_W'(sec_q + 1'b1);
                end else begin
                    tap_q <= TAP_W'(tap_q + 1'b1);
                end
            end
        end
    end

    // ---------------- coefficient staging and working sets ----------------
    logic signed [CW-1:0]     act_c [SECTIONS][NTAPS];
    logic [SECTIONS*NTAPS*CW-1:0] act_flat;
    logic [SECTIONS-1:0]      act_en;

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            localparam logic signed [CW-1:0] RST_VAL = CW'(signed'(coef_default(s, k)));
            logic signed [CW-1:0] stage_q, act_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= RST_VAL;
                    act_q   <= RST_VAL;
                end else begin
                    if (cfg_wr && cfg_addr == ADDR_W'(s * SLOTS + k)) stage_q <= cfg_wdata;
                    if (accept) act_q <= stage_q;
                end
            end
            assign act_c[s][k] = act_q;
            assign act_flat[(s*NTAPS+k)*CW +: CW] = act_q;
        end

        logic en_stage_q, en_act_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_stage_q <= 1'b1;
                en_act_q   <= 1'b1;
            end else begin
                if (cfg_wr && cfg_addr == ADDR_W'(s * SLOTS + NTAPS)) en_stage_q <= cfg_wdata[0];
                if (accept) en_act_q <= en_stage_q;
            end
        end
        assign act_en[s] = en_act_q;
    end

    // ---------------- datapath ----------------
    logic signed [STATE_W-1:0] x_q;
    logic signed [STATE_W-1:0] sec_in_arr [SECTIONS];
    logic signed [STATE_W-1:0] h_x1 [SECTIONS];
    logic signed [STATE_W-1:0] h_x2 [SECTIONS];
    logic signed [STATE_W-1:0] h_y1 [SECTIONS];
    logic signed [STATE_W-1:0] h_y2 [SECTIONS];
    logic signed [STATE_W-1:0] cur_in, opnd, sec_res, wb_val;
    logic signed [CW-1:0]      cf;
    logic signed [ACC_W-1:0]   mac_sum, rnd, shf;
    logic [IN_W-1:0]           out_sat;
    logic                      ovf_s, ovf_o;

    assign sec_in_arr[0] = x_q;
    assign cur_in        = sec_in_arr[sec_q];

    always_comb begin
        unique case (tap_q)
            TAP_W'(0): begin opnd = cur_in;       cf = act_c[sec_q][0]; end
            TAP_W'(1): begin opnd = h_x1[sec_q];  cf = act_c[sec_q][1]; end
            TAP_W'(2): begin opnd = h_x2[sec_q];  cf = act_c[sec_q][2]; end
            TAP_W'(3): begin opnd = h_y1[sec_q];  cf = act_c[sec_q][3]; end
            TAP_W'(4): begin opnd = h_y2[sec_q];  cf = act_c[sec_q][4]; end
            default:   begin opnd = '0;           cf = '0;              end
        endcase
    end

    biq_mac #(.CW(CW), .DW(STATE_W), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (st_q != ST_IDLE),
        .clear (tap_q == '0),
        .sub   (st_q == ST_FBK),
        .coef  (cf),
        .oper  (opnd),
        .sum   (mac_sum)
    );

    // round half up, then clamp into the state width and the output width
    assign rnd     = mac_sum + (ACC_W'(1) <<< (FRAC - 1));
    assign shf     = rnd >>> FRAC;
    assign ovf_s   = !((&shf[ACC_W-1:STATE_W-1]) || !(|shf[ACC_W-1:STATE_W-1]));
    assign sec_res = ovf_s ? {shf[ACC_W-1], {(STATE_W-1){~shf[ACC_W-1]}}} : shf[STATE_W-1:0];
    assign wb_val  = act_en[sec_q] ? sec_res : cur_in;
    assign ovf_o   = !((&wb_val[STATE_W-1:IN_W-1]) || !(|wb_val[STATE_W-1:IN_W-1]));
    assign out_sat = ovf_o ? {wb_val[STATE_W-1], {(IN_W-1){~wb_val[STATE_W-1]}}} : wb_val[IN_W-1:0];

    for (genvar s = 0; s < SECTIONS; s++) begin : g_hist
        biq_hist #(.DW(STATE_W)) u_hist (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (last_tap && sec_q == SEC_W'(s) && act_en[s]),
            .x_new (cur_in),
            .y_new (sec_res),
            .x1    (h_x1[s]),
            .x2    (h_x2[s]),
            .y1    (h_y1[s]),
            .y2    (h_y2[s])
        );

        // R5: a bypassed section keeps its history while samples flow past it
        assert_bypass_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q != ST_IDLE && !act_en[s]) |=> $stable({h_x1[s], h_x2[s], h_y1[s], h_y2[s]}));
    end

    for (genvar s = 1; s < SECTIONS; s++) begin : g_mid
        logic signed [STATE_W-1:0] mid_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mid_q <= '0;
            else if (last_tap && sec_q == SEC_W'(s - 1)) mid_q <= wb_val;
        end
        assign sec_in_arr[s] = mid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q        <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= last_tap && last_sec;
            if (accept) x_q <= STATE_W'(signed'(in_sample));
            if (last_tap && last_sec) out_sample <= out_sat;
        end
    end

    // ---------------- checks ----------------
    logic [LC_W-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_cnt <= '0;
        else if (accept) lat_cnt <= '0;
        else if (st_q != ST_IDLE) lat_cnt <= LC_W'(lat_cnt + 1'b1);
    end

    assert_out_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_cnt == LC_W'(LAT)));

    assert_coef_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(act_flat) && $stable(act_en)));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(x_q));

endmodule

// File: tb/tb_biq_cascade.sv
module tb_biq_cascade;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_sample = '0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic       out_valid;
    logic [9:0] out_sample;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    biq_cascade dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    // ---------------- reference model ----------------
    longint m_c [2][5];
    bit     m_en [2];
    longint mx1 [2], mx2 [2], my1 [2], my2 [2];

    function automatic longint sat(input longint v, input int w);
        longint hi = (64'sd1 <<< (w - 1)) - 1;
        longint lo = -(64'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic model_reset();
        m_c[0][0] = $signed(16'h0825); m_c[0][1] = $signed(16'hF43A); m_c[0][2] = $signed(16'h0825);
        m_c[0][3] = $signed(16'hCEFF); m_c[0][4] = $signed(16'h1613);
        m_c[1][0] = $signed(16'h1DAA); m_c[1][1] = $signed(16'hCBEF); m_c[1][2] = $signed(16'h1DAA);
        m_c[1][3] = $signed(16'hC7F6); m_c[1][4] = $signed(16'h1F4D);
        for (int s = 0; s < 2; s++) begin
            m_en[s] = 1; mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
        end
    endtask

    task automatic model_apply(input int addr, input logic [15:0] data);
        int s = addr / 6;
        int k = addr % 6;
        if (s < 2) begin
            if (k < 5) m_c[s][k] = longint'($signed(data));
            else m_en[s] = data[0];
        end
    endtask

    function automatic longint model_step(input longint x);
        longint v = x;
        for (int s = 0; s < 2; s++) begin
            if (m_en[s]) begin
                longint acc = m_c[s][0]*v + m_c[s][1]*mx1[s] + m_c[s][2]*mx2[s]
                            - m_c[s][3]*my1[s] - m_c[s][4]*my2[s];
                longint y = sat((acc + 4096) >>> 13, 16);
                mx2[s] = mx1[s]; mx1[s] = v; my2[s] = my1[s]; my1[s] = y;
                v = y;
            end
        end
        return sat(v, 10);
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_reset();
    endtask

    task automatic cfg_write(input int addr, input logic [15:0] data);
        cfg_wr = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_apply(addr, data);
    endtask

    // mid_kind: 0 none, 1 extra strobe while busy, 2 config write while busy
    task automatic push_check(input int x, input string req, input int mid_kind = 0,
                              input int ma = 0, input int mb = 0);
        longint exp = model_step(x);
        bit early = 0;
        in_valid = 1'b1; in_sample = 10'(x);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            if (k == 3 && mid_kind == 1) begin in_valid = 1'b1; in_sample = 10'(ma); end
            if (k == 3 && mid_kind == 2) begin cfg_wr = 1'b1; cfg_addr = 4'(ma); cfg_wdata = 16'(mb); end
            if (out_valid) early = 1;
            @(negedge clk);
            in_valid = 1'b0; cfg_wr = 1'b0;
        end
        check(out_valid && !early, "R4", "output strobe timing", longint'(out_valid), 1);
        check($signed(out_sample) == exp, req, "output sample",
              longint'($signed(out_sample)), exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R6", "out_valid in reset", longint'(out_valid), 0);
        check(out_sample == '0, "R6", "out_sample in reset", longint'(out_sample), 0);
        do_reset();
        check(out_valid == 1'b0, "R6", "out_valid after reset", longint'(out_valid), 0);
    endtask

    task automatic t_default_impulse();   // R1, R6
        push_check(400, "R6");
        for (int i = 0; i < 14; i++) push_check(0, "R6");
    endtask

    task automatic t_square();            // R1
        for (int i = 0; i < 24; i++) push_check(((i / 3) % 2 == 0) ? 300 - i : -297 + i, "R1");
        push_check(-512, "R1");
        push_check(511, "R1");
    endtask

    task automatic t_bypass();            // R5
        do_reset();
        cfg_write(5, 16'h0000);
        for (int i = 0; i < 8; i++) push_check(50 * i - 180, "R5");
        cfg_write(5, 16'h0001);
        for (int i = 0; i < 8; i++) push_check(120 - 37 * i, "R5");
        cfg_write(11, 16'h0000);
        cfg_write(5, 16'h0000);
        push_check(-512, "R5");
        check($signed(out_sample) == -512, "R5", "pass-through min", longint'($signed(out_sample)), -512);
        push_check(511, "R5");
        check($signed(out_sample) == 511, "R5", "pass-through max", longint'($signed(out_sample)), 511);
        push_check(-1, "R5");
    endtask

    task automatic t_out_saturation();    // R3
        do_reset();
        for (int s = 0; s < 2; s++) begin
            cfg_write(s * 6 + 0, 16'h7FFF);
            for (int k = 1; k < 5; k++) cfg_write(s * 6 + k, 16'h0000);
        end
        push_check(511, "R3");
        check($signed(out_sample) == 511, "R3", "clamp high", longint'($signed(out_sample)), 511);
        push_check(-512, "R3");
        check($signed(out_sample) == -512, "R3", "clamp low", longint'($signed(out_sample)), -512);
        push_check(10, "R3");
        check($signed(out_sample) == 160, "R3", "in-range gain 16", longint'($signed(out_sample)), 160);
    endtask

    task automatic t_state_saturation();  // R2
        do_reset();
        cfg_write(0, 16'h2000); cfg_write(1, 16'h0000); cfg_write(2, 16'h0000);
        cfg_write(3, 16'hE000); cfg_write(4, 16'h0000);
        cfg_write(6, 16'h0001); cfg_write(7, 16'h0000); cfg_write(8, 16'h0000);
        cfg_write(9, 16'h0000); cfg_write(10, 16'h0000);
        for (int i = 0; i < 70; i++) push_check(500, "R2");
        check($signed(out_sample) == 4, "R2", "integrator clamps at +32767",
              longint'($signed(out_sample)), 4);
    endtask

    task automatic t_busy_strobe();       // R8
        do_reset();
        push_check(200, "R8", 1, 300);
        push_check(-150, "R8", 1, -400);
        push_check(0, "R8");
        push_check(0, "R8");
    endtask

    task automatic t_midflight_write();   // R7
        push_check(250, "R7", 2, 0, 16'h1000);
        model_apply(0, 16'h1000);
        push_check(250, "R7");
        push_check(-90, "R7", 2, 5, 16'h0000);
        model_apply(5, 16'h0000);
        push_check(-90, "R7");
        push_check(33, "R7");
    endtask

    task automatic t_reset_restores();    // R6
        do_reset();
        push_check(-300, "R6");
        for (int i = 0; i < 6; i++) push_check(0, "R6");
    endtask

    initial begin
        model_reset();
        t_reset_state();
        t_default_impulse();
        t_square();
        t_bypass();
        t_out_saturation();
        t_state_saturation();
        t_busy_strobe();
        t_midflight_write();
        t_reset_restores();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule